// File: doc/BRIEF.md
# Two-Step Oscillator Enable Sequencer with Column Noise Patterns

This block controls the enable lines of a rectangular matrix of ring oscillators, 16 rows by 32 columns (512 enables) by default, for a frequency-comparison fingerprint circuit. A challenge names two oscillators and one background pattern for each of them. The block then runs two measurement steps in sequence. In each step it switches on the oscillator being measured and the column-shaped group of extra oscillators that the pattern selects as deliberate switching noise. It waits a programmable settle time and then holds a gate high for a fixed number of cycles. An external counter counts oscillator edges while the gate is high, and the block captures that count.

The enable bit of the oscillator at row r, column c is bit r*COLS + c, so an oscillator index splits into column = index mod COLS and row = index div COLS. The background pattern code is 2 bits wide. Code 00 (quiet) adds nothing. Code 01 (single column) adds the measured oscillator's column. Code 10 (column band) adds that column and its immediate neighbours. Code 11 (flood) adds the whole matrix. The four codes are stored in an enumerated type inside the block. The two steps may use different codes. Flood is meant for the enrolment stability check, and the caller chooses it.

The controller is one state machine with seven states: IDLE, SETTLE_1, GATE_1, LATCH_1, SETTLE_2, GATE_2, LATCH_2. Transitions are: IDLE→SETTLE_1 on start; SETTLE_1→GATE_1 and SETTLE_2→GATE_2 when the settle timer expires; GATE_1→LATCH_1 and GATE_2→LATCH_2 when the gate timer expires; LATCH_1→SETTLE_2 and LATCH_2→IDLE unconditionally.

Top module: `bgn_osc_ctrl`

## Requirements
- R1: While reset is asserted and right after it, osc_en is all zero, gate, busy and done are 0, and count_a and count_b are 0.
- R2: A start pulse in IDLE latches both indices, both pattern codes and settle_cycles, raises busy from the next cycle, and enables are zero and gate is low whenever busy is low.
- R3: Pattern code 00 enables only the measured oscillator: exactly one bit of osc_en is set.
- R4: Pattern code 01 enables all ROWS oscillators of the measured oscillator's column, bits r*COLS + col.
- R5: Pattern code 10 enables the measured column and columns col-1 and col+1 where they exist, so column 0 and column COLS-1 get two columns.
- R6: Pattern code 11 enables all ROWS*COLS oscillators.
- R7: Step one uses meas_a_idx with cfg_a, and step two uses meas_b_idx with cfg_b.
- R8: In each step the enables are on with gate low for settle_cycles+1 cycles before the gate rises.
- R9: The gate stays high for exactly GATE_CYCLES consecutive cycles in each step, and the enables do not change while it is high.
- R10: The cycle after each gate falls has all enables low. The count_in value of that cycle is captured into count_a (step one) or count_b (step two), visible from the following cycle.
- R11: done is high for exactly one cycle after step two, in the first cycle in which count_b is valid and busy is 0.
- R12: start while busy is ignored: the running acquisition, its patterns and its captured counts are unchanged, and no new acquisition follows.
- R13: The measured oscillator's enable bit is 1 for every cycle the gate is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an acquisition (sampled in IDLE only) |
| meas_a_idx | input | $clog2(ROWS*COLS) | Oscillator measured in step one |
| meas_b_idx | input | $clog2(ROWS*COLS) | Oscillator measured in step two |
| cfg_a | input | 2 | Background pattern code for step one |
| cfg_b | input | 2 | Background pattern code for step two |
| settle_cycles | input | SETTLE_W | Settle delay; the settle phase lasts this value plus one |
| count_in | input | CNT_W | Value of the external edge counter |
| osc_en | output | ROWS*COLS | Oscillator enable lines |
| gate | output | 1 | Counting window for the external counter |
| busy | output | 1 | Acquisition in progress |
| count_a | output | CNT_W | Count captured in step one |
| count_b | output | CNT_W | Count captured in step two |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state in the controller shows at the ports within one cycle, as a wrong enable vector or a gate edge in the wrong cycle. Every cycle of every acquisition is therefore compared against the expected mask and gate level. A decoding fault in the pattern generator shows as a mask that differs from the expected row/column set only for certain columns, so the edge columns and the same-oscillator case are driven on purpose. Capture faults show as a count of the wrong step, or as a count taken one cycle early or late. The bench counter ramps with a per-oscillator rate and clears only when all enables are low, so either fault changes the captured value.

// File: rtl/bgn_pkg.sv
package bgn_pkg;

    typedef enum logic [1:0] {
        CFG_QUIET = 2'b00,
        CFG_COL   = 2'b01,
        CFG_BAND  = 2'b10,
        CFG_FLOOD = 2'b11
    } bg_cfg_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE_1,
        ST_GATE_1,
        ST_LATCH_1,
        ST_SETTLE_2,
        ST_GATE_2,
        ST_LATCH_2
    } acq_state_e;

endpackage

// File: rtl/bgn_mask_gen.sv
module bgn_mask_gen
    import bgn_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int COLS  = 32,
    parameter int IDX_W = $clog2(ROWS*COLS)
) (
    input  logic [IDX_W-1:0]     meas_idx,
    input  bg_cfg_e              cfg,
    output logic [ROWS*COLS-1:0] mask
);
    logic [31:0]     col_i;
    logic [COLS-1:0] col_hit;

    assign col_i = 32'(meas_idx) % 32'(COLS);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        always_comb begin
            unique case (cfg)
                CFG_QUIET: col_hit[c] = 1'b0;
                CFG_COL:   col_hit[c] = (col_i == 32'(c));
                CFG_BAND:  col_hit[c] = (col_i == 32'(c)) ||
                                        (col_i == 32'(c + 1)) ||
                                        (col_i + 32'd1 == 32'(c));
                CFG_FLOOD: col_hit[c] = 1'b1;
                default:   col_hit[c] = 1'b0;
            endcase
        end
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign mask[r*COLS + c] = col_hit[c] |
                                      (meas_idx == IDX_W'(r*COLS + c));
        end
    end

endmodule

// File: rtl/bgn_timer.sv
module bgn_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/bgn_osc_ctrl.sv
module bgn_osc_ctrl
    import bgn_pkg::*;
#(
    parameter int ROWS        = 16,
    parameter int COLS        = 32,
    parameter int GATE_CYCLES = 64,
    parameter int CNT_W       = 16,
    parameter int SETTLE_W    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [$clog2(ROWS*COLS)-1:0] meas_a_idx,
    input  logic [$clog2(ROWS*COLS)-1:0] meas_b_idx,
    input  logic [1:0]                   cfg_a,
    input  logic [1:0]                   cfg_b,
    input  logic [SETTLE_W-1:0]          settle_cycles,
    input  logic [CNT_W-1:0]             count_in,
    output logic [ROWS*COLS-1:0]         osc_en,
    output logic                         gate,
    output logic                         busy,
    output logic [CNT_W-1:0]             count_a,
    output logic [CNT_W-1:0]             count_b,
    output logic                         done
);
    localparam int N      = ROWS * COLS;
    localparam int IDX_W  = $clog2(N);
    localparam int GATE_W = $clog2(GATE_CYCLES);
    localparam int TMR_W  = (SETTLE_W > GATE_W) ? SETTLE_W : GATE_W;
    localparam int GCHK_W = $clog2(GATE_CYCLES + 1);

    acq_state_e state_q, state_d;

    logic [IDX_W-1:0]    idx_a_q, idx_b_q, meas_idx;
    bg_cfg_e             cfg_a_q, cfg_b_q, meas_cfg;
    logic [SETTLE_W-1:0] settle_q;
    logic                tmr_load, tmr_exp;
    logic [TMR_W-1:0]    tmr_val;
    logic                en_active, step_two;
    logic [N-1:0]        mask;
    logic [CNT_W-1:0]    count_a_q, count_b_q;
    logic                done_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d  = ST_SETTLE_1;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(settle_cycles);
            end
            ST_SETTLE_1: if (tmr_exp) begin
                state_d  = ST_GATE_1;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(GATE_CYCLES - 1);
            end
            ST_GATE_1: if (tmr_exp) state_d = ST_LATCH_1;
            ST_LATCH_1: begin
                state_d  = ST_SETTLE_2;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(settle_q);
            end
            ST_SETTLE_2: if (tmr_exp) begin
                state_d  = ST_GATE_2;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(GATE_CYCLES - 1);
            end
            ST_GATE_2:  if (tmr_exp) state_d = ST_LATCH_2;
            ST_LATCH_2: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        gate      = 1'b0;
        en_active = 1'b0;
        step_two  = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE:     busy = 1'b0;
            ST_SETTLE_1: en_active = 1'b1;
            ST_GATE_1:   begin en_active = 1'b1; gate = 1'b1; end
            ST_LATCH_1:  ;
            ST_SETTLE_2: begin en_active = 1'b1; step_two = 1'b1; end
            ST_GATE_2:   begin en_active = 1'b1; step_two = 1'b1; gate = 1'b1; end
            ST_LATCH_2:  step_two = 1'b1;
            default:     busy = 1'b0;
        endcase
    end

    // challenge latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_a_q  <= '0;
            idx_b_q  <= '0;
            cfg_a_q  <= CFG_QUIET;
            cfg_b_q  <= CFG_QUIET;
            settle_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            idx_a_q  <= meas_a_idx;
            idx_b_q  <= meas_b_idx;
            cfg_a_q  <= bg_cfg_e'(cfg_a);
            cfg_b_q  <= bg_cfg_e'(cfg_b);
            settle_q <= settle_cycles;
        end
    end

    // count capture and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_a_q <= '0;
            count_b_q <= '0;
            done_q    <= 1'b0;
        end else begin
            if (state_q == ST_LATCH_1) count_a_q <= count_in;
            if (state_q == ST_LATCH_2) count_b_q <= count_in;
            done_q <= (state_q == ST_LATCH_2);
        end
    end

    bgn_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    assign meas_idx = step_two ? idx_b_q : idx_a_q;
    assign meas_cfg = step_two ? cfg_b_q : cfg_a_q;

    bgn_mask_gen #(.ROWS(ROWS), .COLS(COLS), .IDX_W(IDX_W)) u_mask (
        .meas_idx (meas_idx),
        .cfg      (meas_cfg),
        .mask     (mask)
    );

    assign osc_en  = en_active ? mask : '0;
    assign count_a = count_a_q;
    assign count_b = count_b_q;
    assign done    = done_q;

    // ---------------- assertions ----------------
    logic [GCHK_W-1:0] gate_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    gate_run_q <= '0;
        else if (gate) gate_run_q <= gate_run_q + 1'b1;
        else           gate_run_q <= '0;
    end

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!gate && osc_en == '0));

    p_cfg_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && meas_cfg == CFG_QUIET) |-> ($countones(osc_en) == 1));

    p_cfg_flood_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && meas_cfg == CFG_FLOOD) |-> (&osc_en));

    p_gate_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> (gate_run_q == GCHK_W'(GATE_CYCLES)));

    p_gate_en_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && $past(gate)) |-> $stable(osc_en));

    p_quiet_after_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> (osc_en == '0));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_meas_on_r13: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> osc_en[meas_idx]);

endmodule

// File: tb/tb_bgn_osc_ctrl.sv
module tb_bgn_osc_ctrl;
    localparam int ROWS = 16, COLS = 32, GATE = 64, CW = 16, SW = 8;
    localparam int N = ROWS * COLS;
    localparam int IW = $clog2(N);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [IW-1:0] ia = '0, ib = '0;
    logic [1:0] ca = '0, cb = '0;
    logic [SW-1:0] sl = '0;
    logic [CW-1:0] ext_cnt;
    logic [N-1:0] osc_en;
    logic gate, busy, done;
    logic [CW-1:0] count_a, count_b;
    int cur_inc = 1;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bgn_osc_ctrl #(.ROWS(ROWS), .COLS(COLS), .GATE_CYCLES(GATE), .CNT_W(CW), .SETTLE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .meas_a_idx(ia), .meas_b_idx(ib),
        .cfg_a(ca), .cfg_b(cb), .settle_cycles(sl), .count_in(ext_cnt),
        .osc_en(osc_en), .gate(gate), .busy(busy), .count_a(count_a),
        .count_b(count_b), .done(done));

    // external edge counter model: ramps while gated, clears when all enables are off
    always @(posedge clk) begin
        if (!rst_n)              ext_cnt <= '0;
        else if (gate)           ext_cnt <= ext_cnt + CW'(cur_inc);
        else if (osc_en == '0)   ext_cnt <= '0;
    end

    function automatic logic [N-1:0] exp_mask(int idx, int cfg);
        logic [N-1:0] m = '0;
        int mc = idx % COLS;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                bit hit = 0;
                if (cfg == 1) hit = (c == mc);
                if (cfg == 2) hit = (c >= mc - 1) && (c <= mc + 1);
                if (cfg == 3) hit = 1;
                if (r*COLS + c == idx) hit = 1;
                m[r*COLS + c] = hit;
            end
        return m;
    endfunction

    function automatic int rate(int idx);
        return (idx % 5) + 1;
    endfunction

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic pattern_chk(logic [N-1:0] m, int cfg, int idx);
        case (cfg)
            0: chk("R3 quiet pattern", m, exp_mask(idx, 0));
            1: chk("R4 column pattern", m, exp_mask(idx, 1));
            2: chk("R5 band pattern", m, exp_mask(idx, 2));
            default: chk("R6 flood pattern", m, exp_mask(idx, 3));
        endcase
    endtask

    task automatic run_acq(int a, int b, int cfa, int cfb, int s, bit poke);
        logic [N-1:0] ma = exp_mask(a, cfa);
        logic [N-1:0] mb = exp_mask(b, cfb);
        @(negedge clk);
        start = 1; ia = IW'(a); ib = IW'(b); ca = 2'(cfa); cb = 2'(cfb); sl = SW'(s);
        cur_inc = rate(a);
        @(negedge clk);
        start = 0; ia = IW'($urandom); ib = IW'($urandom); ca = 2'($urandom); cb = 2'($urandom);
        sl = SW'($urandom);
        chk("R2 busy after start", N'(busy), N'(1));
        // step one settle
        for (int k = 0; k <= s; k++) begin
            chk("R8 settle gate low", N'(gate), N'(0));
            chk("R7 step one mask", osc_en, ma);
            @(negedge clk);
        end
        pattern_chk(osc_en, cfa, a);
        for (int k = 0; k < GATE; k++) begin
            chk("R9 gate high", N'(gate), N'(1));
            chk("R13 measured osc on", N'(osc_en[a]), N'(1));
            chk("R7 step one mask in gate", osc_en, ma);
            @(negedge clk);
        end
        chk("R9 gate closed", N'(gate), N'(0));
        chk("R10 quiet between steps", osc_en, '0);
        cur_inc = rate(b);
        if (poke) begin
            start = 1; ia = IW'(a ^ 5); ib = IW'(b ^ 9); ca = 2'(cfa + 1); cb = 2'(cfb + 2); sl = 0;
        end
        @(negedge clk);
        start = 0;
        chk("R10 count_a captured", N'(count_a), N'(GATE * rate(a)));
        for (int k = 0; k <= s; k++) begin
            chk("R8 settle two gate low", N'(gate), N'(0));
            chk("R7 step two mask", osc_en, mb);
            if (poke) chk("R12 start ignored mid run", osc_en, mb);
            @(negedge clk);
        end
        pattern_chk(osc_en, cfb, b);
        for (int k = 0; k < GATE; k++) begin
            chk("R9 gate two high", N'(gate), N'(1));
            chk("R13 measured osc on step two", N'(osc_en[b]), N'(1));
            chk("R7 step two mask in gate", osc_en, mb);
            @(negedge clk);
        end
        chk("R10 quiet after step two", osc_en, '0);
        chk("R11 done not early", N'(done), N'(0));
        @(negedge clk);
        chk("R11 done pulse", N'(done), N'(1));
        chk("R11 idle at done", N'(busy), N'(0));
        chk("R11 count_b captured", N'(count_b), N'(GATE * rate(b)));
        chk("R12 count_a held", N'(count_a), N'(GATE * rate(a)));
        @(negedge clk);
        chk("R11 done one cycle", N'(done), N'(0));
        chk("R12 no new run", N'(busy), N'(0));
        chk("R2 idle enables off", osc_en, '0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R1 reset enables", osc_en, '0);
        chk("R1 reset gate", N'(gate), N'(0));
        chk("R1 reset busy", N'(busy), N'(0));
        chk("R1 reset done", N'(done), N'(0));
        chk("R1 reset counts", N'({count_a, count_b}), N'(0));
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset", N'({gate, busy, done}), N'(0));
        // directed corner cases
        run_acq(0, 1, 0, 0, 0, 0);              // quiet, settle 0
        run_acq(32*3, 31, 2, 2, 1, 0);          // band at column 0 and column COLS-1
        run_acq(32*7 + 15, 32*2 + 15, 1, 3, 3, 0); // column then flood
        run_acq(200, 200, 0, 3, 2, 1);          // same oscillator, start poked while busy
        run_acq(N - 1, 33, 2, 1, 7, 0);         // last oscillator, band at edge
        for (int t = 0; t < 24; t++)
            run_acq($urandom % N, $urandom % N, $urandom % 4, $urandom % 4,
                    $urandom % 6, bit'($urandom % 2));
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired t=%0t actual=hung expected=finished", $time);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule